// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is an eight-stage shift register. It captures a word from a parallel bus and then moves it out one bit at a time through its last stage. That stage drives a true output and a complemented output. An active-low load input overrides everything else. While it is low, the parallel word is forced into the stages and appears at the outputs in the same cycle, whatever the clock inputs are doing.

Shifting is driven by two clock inputs, combined as a NOR-style gate. If either input is held high, the register is frozen. If one input is held low, the other input acts as the clock. The block does not build a derived clock from these inputs. It registers both of them on the system clock through a short synchronizer. It then steps the register by one stage when their OR changes from low to high. On each step, a serial input enters the first stage and every other stage takes the value of the stage before it. Exposing that serial input lets one register feed another.

Top module: `gated_pload_shifter`

## Requirements
- R1: A synchronous active-low reset clears every stage to 0. With the load input high, this gives a true output of 0 and a complement output of 1.
- R2: When the load input is low, the true output equals the most significant parallel bit in the same cycle, before any clock edge.
- R3: While the load input stays low, the stages hold the parallel word. Transitions on either clock input have no effect during that time.
- R4: With the load input high, a low-to-high change of the OR of the two clock inputs advances the register by exactly one stage. The result reaches the outputs SYNC_DEPTH+1 system clock edges after the input change.
- R5: While either clock input is held high, transitions on the other clock input do not shift the register.
- R6: When no qualifying rising change occurs with the load input high, all stages keep their contents.
- R7: The complement output is always the inverse of the true output.
- R8: Stage order is fixed. Parallel bit 0 loads the first stage and bit WIDTH-1 loads the last stage. After k shifts the true output shows parallel bit WIDTH-1-k. After WIDTH shifts, the stages hold only serial-input data, with the oldest serial bit in the last stage.
- R9: When the clock inputs fall back to low (the OR changes from high to low), the register does not shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Active-low parallel load, level-sensitive override |
| ck_a | input | 1 | Clock input A of the NOR-style clock gate |
| ck_b | input | 1 | Clock input B of the NOR-style clock gate, usable as an inhibit |
| ser_in | input | 1 | Serial data for the first stage |
| par_in | input | WIDTH | Parallel data; bit 0 goes to the first stage |
| q_last | output | 1 | True output of the last stage |
| q_last_n | output | 1 | Complemented output of the last stage |

## Verification
The step-by-step assertions assume three things about the inputs. The serial bit must be stable at the system edge where a shift is taken. The clock inputs must stay at each level for more than one system cycle, so that each low-to-high change of their OR produces exactly one step. The parallel word must be steady while the load input is low. The stimulus meets these assumptions. It changes inputs only on falling system edges. It holds every clock-input level for SYNC_DEPTH+3 cycles before the next change. It never changes the load input in the same cycle as a clock input.

// File: rtl/shr_pkg.sv
// Shared types for the gated-clock shift register.
// Assumes: nothing beyond a standard SystemVerilog compile order.
package shr_pkg;

    // Register action chosen for a given system cycle.
    typedef enum logic [1:0] {
        SHR_HOLD  = 2'd0,
        SHR_SHIFT = 2'd1,
        SHR_LOAD  = 2'd2
    } shr_act_e;

endpackage

// File: rtl/shr_clk_qual.sv
// Synchronizes the two external clock inputs to the system clock.
// It emits a one-cycle advance pulse when their OR rises, which gives
// the NOR-style clock gate its behaviour.
// Assumes: each clock-input level lasts at least two system cycles.
// Reset fills the synchronizers with 1s, so releasing reset while
// an input is high does not look like an edge.
module shr_clk_qual #(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ck_a,
    input  logic ck_b,
    output logic adv
);
    localparam int unsigned TOP = SYNC_DEPTH - 1;

    logic [TOP:0] sync_a;
    logic [TOP:0] sync_b;
    logic         gate_now;
    logic         gate_prev;

    generate
        if (SYNC_DEPTH == 1) begin : g_sync_one
            // Purpose: single flop capture of both clock inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_a <= '1;
                    sync_b <= '1;
                end else begin
                    sync_a <= ck_a;
                    sync_b <= ck_b;
                end
            end
        end else begin : g_sync_chain
            // Purpose: multi-flop synchronizer chains for both clock inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_a <= '1;
                    sync_b <= '1;
                end else begin
                    sync_a <= {sync_a[TOP-1:0], ck_a};
                    sync_b <= {sync_b[TOP-1:0], ck_b};
                end
            end
        end
    endgenerate

    assign gate_now = sync_a[TOP] | sync_b[TOP];

    // Purpose: remember the previous gated level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_prev <= 1'b1;
        else        gate_prev <= gate_now;
    end

    assign adv = gate_now & ~gate_prev;

    // One rising change of the gate gives exactly one advance pulse.
    assert_one_step_per_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !adv);

    // A falling gate (inputs returning low) never advances.
    assert_no_step_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_now && $past(gate_now)) |-> !adv);

endmodule

// File: rtl/shr_ctrl.sv
// Chooses the register action for the cycle. The level of the load
// input has priority over any advance pulse, which models a load that
// overrides the clock.
// Assumes: adv is a single-cycle pulse.
module shr_ctrl
    import shr_pkg::*;
(
    input  logic     load_n,
    input  logic     adv,
    output shr_act_e act
);
    // Purpose: priority decode of load, shift and hold.
    always_comb begin
        if (!load_n)  act = SHR_LOAD;
        else if (adv) act = SHR_SHIFT;
        else          act = SHR_HOLD;
    end
endmodule

// File: rtl/shr_stage_bank.sv
// Holds the WIDTH stages. Stage 0 takes the serial bit on a shift and
// stage i takes stage i-1. The view output shows the parallel word
// while a load is active, so that loaded data is visible in the same
// cycle.
// Assumes: ser_in is stable at the sampling edge.
module shr_stage_bank
    import shr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  shr_act_e         act,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] view
);
    localparam int unsigned LAST = WIDTH - 1;

    logic [WIDTH-1:0] st;
    logic [WIDTH-1:0] src;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign src[i] = ser_in;
            end else begin : g_body
                assign src[i] = st[i-1];
            end

            // Purpose: per-stage update for load, shift or hold.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st[i] <= 1'b0;
                end else begin
                    case (act)
                        SHR_LOAD:  st[i] <= par_in[i];
                        SHR_SHIFT: st[i] <= src[i];
                        default:   st[i] <= st[i];
                    endcase
                end
            end
        end
    endgenerate

    assign view = (act == SHR_LOAD) ? par_in : st;

    // A held load keeps the parallel word in the stages.
    assert_load_captures_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act == SHR_LOAD) |=> (st == $past(par_in)));

    // A shift moves every stage by one position, serial bit into the head.
    assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act == SHR_SHIFT) |=> (st == {$past(st[LAST-1:0]), $past(ser_in)}));

    // Without a load or an advance, the contents stay put.
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == SHR_HOLD) |=> $stable(st));

endmodule

// File: rtl/gated_pload_shifter.sv
// Top level of the gated-clock parallel-load shift register. It ties
// together the clock qualifier, the action decode and the stage bank,
// and drives true and complemented copies of the last stage.
// Assumes: all inputs are driven from logic related to clk, except
// ck_a and ck_b, which pass through synchronizers.
module gated_pload_shifter
    import shr_pkg::*;
#(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             ck_a,
    input  logic             ck_b,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             q_last,
    output logic             q_last_n
);
    localparam int unsigned LAST = WIDTH - 1;

    logic             adv;
    shr_act_e         act;
    logic [WIDTH-1:0] view;

    shr_clk_qual #(.SYNC_DEPTH(SYNC_DEPTH)) u_clk_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .ck_a  (ck_a),
        .ck_b  (ck_b),
        .adv   (adv)
    );

    shr_ctrl u_ctrl (
        .load_n (load_n),
        .adv    (adv),
        .act    (act)
    );

    shr_stage_bank #(.WIDTH(WIDTH)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .par_in (par_in),
        .ser_in (ser_in),
        .view   (view)
    );

    assign q_last   = view[LAST];
    assign q_last_n = ~view[LAST];

    // A low load shows the top parallel bit at the pins at once.
    assert_load_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> (q_last == par_in[LAST]));

    // The two outputs always disagree.
    assert_outputs_complement_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q_last_n != q_last);

endmodule

// File: tb/gated_pload_shifter_bench.sv
// Scoreboard bench. Driver tasks update a reference model and push
// expected outputs into a queue; a monitor pops and compares them.
module gated_pload_shifter_bench;
    localparam int unsigned WIDTH      = 8;
    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned SETTLE     = SYNC_DEPTH + 3;

    typedef struct {
        logic  exp_q;
        string tag;
    } exp_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_n = 1'b1;
    logic             ck_a = 1'b0;
    logic             ck_b = 1'b0;
    logic             ser_in = 1'b0;
    logic [WIDTH-1:0] par_in = '0;
    logic             q_last;
    logic             q_last_n;

    logic [WIDTH-1:0] model = '0;
    logic             prev_or = 1'b0;
    exp_item_t        exp_q[$];
    int               n_checks = 0;
    int               n_fail = 0;
    bit               done = 1'b0;

    always #10 clk = ~clk;

    gated_pload_shifter #(.WIDTH(WIDTH), .SYNC_DEPTH(SYNC_DEPTH)) u_gated_pload_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .ck_a     (ck_a),
        .ck_b     (ck_b),
        .ser_in   (ser_in),
        .par_in   (par_in),
        .q_last   (q_last),
        .q_last_n (q_last_n)
    );

    task automatic check(input logic exp, input string tag);
        n_checks++;
        if (q_last !== exp || q_last_n !== ~exp) begin
            n_fail++;
            $display("FAIL %s: q_last=%0b q_last_n=%0b expected %0b/%0b",
                     tag, q_last, q_last_n, exp, ~exp);
        end
    endtask

    task automatic push(input string tag);
        exp_item_t it;
        it.exp_q = model[WIDTH-1];
        it.tag   = tag;
        exp_q.push_back(it);
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    // Drive both clock inputs; the model shifts on a rise of their OR.
    task automatic set_clks(input logic a, input logic b, input logic sbit, input string tag);
        @(negedge clk);
        ser_in = sbit;
        ck_a   = a;
        ck_b   = b;
        if (load_n && !prev_or && (a | b)) model = {model[WIDTH-2:0], sbit};
        prev_or = a | b;
        settle();
        push(tag);
    endtask

    task automatic load_word(input logic [WIDTH-1:0] w);
        @(negedge clk);
        par_in = w;
        load_n = 1'b0;
        #2;
        check(w[WIDTH-1], "R2 same-cycle load");
        model = w;
        settle();
        push("R3 load held");
    endtask

    task automatic release_load();
        @(negedge clk);
        load_n = 1'b1;
        settle();
        push("R6 after load release");
    endtask

    // Monitor: compare queued expectations away from the active edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(it.exp_q, it.tag);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected done=1 got 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [WIDTH-1:0] serial_pat;
        serial_pat = 8'b1011_0010;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        settle();
        push("R1 reset state");

        // R8: load and read out through clock A, checking bit order
        load_word(8'b1010_0101);
        release_load();
        for (int k = 0; k < WIDTH; k++) begin
            set_clks(1'b1, 1'b0, serial_pat[WIDTH-1-k], "R4 R8 shift via ck_a");
            set_clks(1'b0, 1'b0, 1'b0, "R9 falling clock no shift");
        end
        // R8: stages now hold only serial data; read it out via clock B
        for (int k = 0; k < WIDTH; k++) begin
            set_clks(1'b0, 1'b1, 1'b0, "R8 serial readout via ck_b");
            set_clks(1'b0, 1'b0, 1'b0, "R9 falling clock no shift");
        end

        // R5: ck_b high inhibits edges on ck_a
        load_word(8'b1100_0011);
        release_load();
        set_clks(1'b0, 1'b1, 1'b0, "R4 ck_b rise shifts");
        set_clks(1'b1, 1'b1, 1'b1, "R5 inhibit by ck_b");
        set_clks(1'b0, 1'b1, 1'b1, "R5 inhibit by ck_b");
        set_clks(1'b1, 1'b1, 1'b0, "R5 inhibit by ck_b");
        set_clks(1'b1, 1'b0, 1'b0, "R5 inhibit by ck_b");
        set_clks(1'b0, 1'b0, 1'b0, "R9 release to low");
        // R5: ck_a high inhibits edges on ck_b
        set_clks(1'b1, 1'b0, 1'b1, "R4 ck_a rise shifts");
        set_clks(1'b1, 1'b1, 1'b0, "R5 inhibit by ck_a");
        set_clks(1'b1, 1'b0, 1'b0, "R5 inhibit by ck_a");
        set_clks(1'b1, 1'b1, 1'b1, "R5 inhibit by ck_a");
        set_clks(1'b0, 1'b0, 1'b1, "R9 release to low");

        // R3: load during active clocking ignores clock edges
        @(negedge clk);
        par_in = 8'b0111_1110;
        load_n = 1'b0;
        model  = 8'b0111_1110;
        for (int k = 0; k < 3; k++) begin
            set_clks(1'b1, 1'b0, 1'b1, "R3 clock ignored during load");
            set_clks(1'b0, 1'b0, 1'b1, "R3 clock ignored during load");
        end
        release_load();
        // R6: idle cycles keep contents; R8 next shift exposes bit 6
        repeat (4) @(negedge clk);
        push("R6 idle hold");
        set_clks(1'b1, 1'b0, 1'b0, "R8 shift exposes bit 6");
        set_clks(1'b0, 1'b0, 1'b0, "R9 release to low");

        // R1: reset clears a loaded word
        load_word(8'b1111_1111);
        release_load();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        settle();
        push("R1 reset clears stages");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule